// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one character into one asynchronous serial frame on a single output line. A client presents a character with a valid strobe while the block shows ready. At that clock edge the block captures the character and four mode bits. The mode bits select 7 or 8 data bits, one or two stop bits, whether a parity bit is sent, and whether that parity is odd or even. The line then carries the whole frame and returns to its resting high level.

The bit rate comes from an external baud generator through a one-cycle bit tick. Each tick ends the bit that is currently on the line. When the tick stops, for example because a debug freeze gates the baud clock, the line and the handshake stay exactly where they are.

Top module: `sertx_frame`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_o` is 1 and `ready_o` is 1. A bit tick while idle changes neither.
- R2: A character is accepted on a clock edge where `chr_valid_i` and `ready_o` are both 1. From the next cycle `tx_o` carries exactly one start bit of value 0. That start bit lasts until the first bit tick.
- R3: After the start bit, the data bits follow least significant bit first, one per tick. There are 8 data bits (`chr_i[0]` to `chr_i[7]`) when `len8_i`=1. There are 7 (`chr_i[0]` to `chr_i[6]`) when `len8_i`=0, and in that mode `chr_i[7]` is never sent.
- R4: The frame ends with stop bits of value 1. There is one stop bit when `stop2_i`=0 and two when `stop2_i`=1.
- R5: With `par_en_i`=1, one parity bit follows the last data bit. With `par_odd_i`=1 the count of ones in the sent data bits plus the parity bit is odd. With `par_odd_i`=0 that count is even. In 7-bit mode `chr_i[7]` takes no part in the parity.
- R6: With `par_en_i`=0 no parity bit is sent, whatever `par_odd_i` holds. The first stop bit directly follows the last data bit.
- R7: The character and mode bits are captured at acceptance. Changes to them during a frame do not alter that frame.
- R8: `ready_o` is 0 from the cycle after acceptance until the cycle after the tick that ends the final stop bit. A `chr_valid_i` seen while `ready_o` is 0 starts no frame.
- R9: In any cycle of a frame that has no bit tick, `tx_o` and `ready_o` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chr_i | input | 8 | Character to send |
| chr_valid_i | input | 1 | Character request strobe |
| len8_i | input | 1 | 1: eight data bits, 0: seven |
| stop2_i | input | 1 | 1: two stop bits, 0: one |
| par_en_i | input | 1 | 1: send a parity bit |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| bit_tick_i | input | 1 | One-cycle pulse that ends the current bit |
| tx_o | output | 1 | Serial line, rests high |
| ready_o | output | 1 | Block can accept a character |

## Verification
The start bit and the drop of `ready_o` both appear one clock after the accepting edge. Every later bit appears one clock after the edge that consumes a tick. `ready_o` returns one clock after the edge that consumes the final tick. The bench drives inputs and samples outputs on falling edges, so each check lands half a period after the register that feeds it has updated. Cycles with no tick are placed inside every bit to observe the hold behaviour.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_MAX   = 8;
    localparam int STOP_MAX   = 2;
    localparam int FRAME_MAX  = 1 + DATA_MAX + 1 + STOP_MAX;
    localparam int CNT_W      = $clog2(FRAME_MAX + 1);

    typedef struct packed {
        logic len8;
        logic stop2;
        logic par_en;
        logic par_odd;
    } sertx_mode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } sertx_state_t;

    // parity bit over the first n bits of d
    function automatic logic par_bit(input logic [DATA_MAX-1:0] d,
                                     input int unsigned         n,
                                     input logic                odd);
        logic acc;
        acc = odd;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < n) acc = acc ^ d[i];
        end
        return acc;
    endfunction

endpackage

// File: rtl/sertx_frame_pack.sv
module sertx_frame_pack
    import sertx_pkg::*;
#(
    parameter int DW = DATA_MAX,
    localparam int FW = 1 + DW + 1 + STOP_MAX,
    localparam int CW = $clog2(FW + 1)
) (
    input  logic [DW-1:0]  chr_i,
    input  sertx_mode_t    mode_i,
    output logic [FW-1:0]  frame_o,
    output logic [CW-1:0]  nbits_o
);
    int unsigned ndata;
    int unsigned nstop;
    int unsigned npar;

    always_comb begin
        ndata   = mode_i.len8 ? DW : DW - 1;
        nstop   = mode_i.stop2 ? 2 : 1;
        npar    = mode_i.par_en ? 1 : 0;
        frame_o = '1;
        frame_o[0] = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (i < ndata) frame_o[1 + i] = chr_i[i];
        end
        if (mode_i.par_en)
            frame_o[1 + ndata] = par_bit(chr_i, ndata, mode_i.par_odd);
        nbits_o = CW'(1 + ndata + npar + nstop);
    end
endmodule

// File: rtl/sertx_shift_engine.sv
module sertx_shift_engine
    import sertx_pkg::*;
#(
    parameter int FW = FRAME_MAX,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [FW-1:0] frame_i,
    input  logic [CW-1:0] nbits_i,
    input  logic          tick_i,
    output logic          tx_o,
    output logic          busy_o
);
    sertx_state_t  st;
    logic [FW-1:0] sreg;
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            sreg <= '1;
            left <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (load_i) begin
                        sreg <= frame_i;
                        left <= nbits_i;
                        st   <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tick_i) begin
                        if (left == CW'(1)) begin
                            sreg <= '1;
                            left <= '0;
                            st   <= ST_IDLE;
                        end else begin
                            sreg <= {1'b1, sreg[FW-1:1]};
                            left <= left - CW'(1);
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign tx_o   = sreg[0];
    assign busy_o = (st == ST_SEND);
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] chr_i,
    input  logic       chr_valid_i,
    input  logic       len8_i,
    input  logic       stop2_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    input  logic       bit_tick_i,
    output logic       tx_o,
    output logic       ready_o
);
    sertx_mode_t          mode;
    logic [FRAME_MAX-1:0] frame;
    logic [CNT_W-1:0]     nbits;
    logic                 busy;
    logic                 load;

    assign mode = '{len8: len8_i, stop2: stop2_i, par_en: par_en_i, par_odd: par_odd_i};
    assign load = chr_valid_i & ~busy;

    sertx_frame_pack #(.DW(DATA_MAX)) u_pack (
        .chr_i   (chr_i),
        .mode_i  (mode),
        .frame_o (frame),
        .nbits_o (nbits)
    );

    sertx_shift_engine #(.FW(FRAME_MAX), .CW(CNT_W)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .frame_i (frame),
        .nbits_i (nbits),
        .tick_i  (bit_tick_i),
        .tx_o    (tx_o),
        .busy_o  (busy)
    );

    assign ready_o = ~busy;
endmodule

// File: rtl/sertx_frame_chk.sv
module sertx_frame_chk (
    input logic clk,
    input logic rst,
    input logic chr_valid_i,
    input logic bit_tick_i,
    input logic tx_o,
    input logic ready_o
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> tx_o); // R1

    AST_START_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (ready_o && chr_valid_i) |=> (!tx_o && !ready_o)); // R2

    AST_LAST_BIT_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> $past(tx_o)); // R4

    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> $past(bit_tick_i)); // R8

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && !bit_tick_i) |=> ($stable(tx_o) && !ready_o)); // R9
endmodule

bind sertx_frame sertx_frame_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .chr_valid_i (chr_valid_i),
    .bit_tick_i  (bit_tick_i),
    .tx_o        (tx_o),
    .ready_o     (ready_o)
);

// File: tb/sertx_frame_tb.sv
module sertx_frame_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] chr = '0;
    logic       vld = 1'b0;
    logic       l8 = 1'b0, s2 = 1'b0, pe = 1'b0, po = 1'b0;
    logic       tick = 1'b0;
    logic       tx, rdy;
    int         checks = 0;
    int         fails = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    sertx_frame dut_i (
        .clk(clk), .rst(rst), .chr_i(chr), .chr_valid_i(vld),
        .len8_i(l8), .stop2_i(s2), .par_en_i(pe), .par_odd_i(po),
        .bit_tick_i(tick), .tx_o(tx), .ready_o(rdy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx == 1'b1, "R1 idle line", tx, 1);
        chk(rdy == 1'b1, "R1 idle ready", rdy, 1);
        pulse_tick();
        @(negedge clk);
        chk(tx == 1'b1 && rdy == 1'b1, "R1 tick while idle", {tx, rdy}, 3);
    endtask

    // send one frame; scramble changes all inputs mid-frame and holds valid
    task automatic t_frame(input logic [7:0] c, input bit m8, input bit m2,
                           input bit mpe, input bit mpo, input bit scramble);
        bit    exp [16];
        string tag [16];
        int    n, nd;
        bit    p;
        @(negedge clk);
        chr = c; l8 = m8; s2 = m2; pe = mpe; po = mpo; vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
        if (scramble) begin
            chr = ~c; l8 = ~m8; s2 = ~m2; pe = ~mpe; po = ~mpo; vld = 1'b1;
        end
        nd = m8 ? 8 : 7;
        n = 0;
        exp[n] = 1'b0; tag[n] = "R2 start"; n++;
        p = mpo;
        for (int i = 0; i < nd; i++) begin
            exp[n] = c[i]; tag[n] = "R3 data"; n++;
            p = p ^ c[i];
        end
        if (mpe) begin
            exp[n] = p; tag[n] = "R5 parity"; n++;
        end
        exp[n] = 1'b1; tag[n] = mpe ? "R4 stop" : "R6 stop after data"; n++;
        if (m2) begin
            exp[n] = 1'b1; tag[n] = "R4 second stop"; n++;
        end
        for (int k = 0; k < n; k++) begin
            string t;
            t = scramble ? {"R7 ", tag[k]} : tag[k];
            chk(tx == exp[k], t, tx, exp[k]);
            chk(rdy == 1'b0, "R8 busy during frame", rdy, 0);
            repeat (2) @(negedge clk);
            chk(tx == exp[k] && rdy == 1'b0, "R9 hold without tick", {tx, rdy}, {exp[k], 1'b0});
            if (k == n - 1) vld = 1'b0;
            pulse_tick();
        end
        chk(rdy == 1'b1, "R8 ready after final stop", rdy, 1);
        chk(tx == 1'b1, "R1 line high after frame", tx, 1);
        if (scramble) begin
            for (int k = 0; k < 3; k++) begin
                pulse_tick();
                chk(tx == 1'b1, "R8 valid while busy ignored", tx, 1);
            end
        end
    endtask

    initial begin
        t_reset();
        t_frame(8'hA5, 1, 0, 0, 0, 0);
        t_frame(8'h3C, 1, 1, 0, 0, 0);
        t_frame(8'hD3, 0, 0, 0, 1, 0);
        t_frame(8'h81, 0, 1, 1, 0, 0);
        t_frame(8'h81, 0, 0, 1, 1, 0);
        t_frame(8'h07, 1, 0, 1, 0, 0);
        t_frame(8'h07, 1, 1, 1, 1, 0);
        t_frame(8'h00, 1, 0, 1, 1, 0);
        t_frame(8'hFF, 0, 0, 1, 0, 0);
        t_frame(8'h5A, 0, 0, 1, 1, 1);
        t_frame(8'hC6, 1, 1, 0, 0, 1);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule